// File: doc/BRIEF.md
# Host Command Interpreter Controller

This block sits behind a host link that has already assembled 32-bit words. It takes those words over a valid/ready interface and treats each one either as a command or as a parameter of the command in progress. The commands cover playback control (start, mute, unmute, two kinds of stop, no-operation), access to a 32-bit RAM through a single-port word interface, and requests for status and a version constant. Every accepted word produces one progress word on the cycle after it is accepted. The progress word tells the host how many parameter words are still owed and whether the word was rejected.

Answers to status, version and RAM-read requests are not returned right away. They are placed in a reply queue of 16 entries. The host fetches them one at a time with a read command, and each read returns its reply word in the same cycle as that command's progress word. Errors set a sticky flag that only reset clears.

Top module: `host_cmd_ctrl`

## Requirements
- R1: The command word carries an opcode in bits [31:24]. Opcode 0x01 (start) sets `playing` and clears `muted`.
- R2: Opcode 0x02 sets `muted` and opcode 0x03 clears it. Neither of them changes `playing`.
- R3: Opcode 0x04 clears `playing` and sets `muted`, and leaves `flush` low. Opcode 0x05 does the same and also raises `flush` for exactly one cycle.
- R4: Opcode 0x00 changes no output state, and its progress word is 0x00000000.
- R5: Each accepted word yields exactly one progress word one cycle after acceptance. Bit 31 is the error bit, bits [7:0] give the parameter words still expected, and all other bits are zero.
- R6: Opcode 0x20 takes a count N in bits [23:16] and a start address in bits [15:0]. The next N accepted words are treated as data whatever their contents, and are written to consecutive addresses. The progress word reads N for the command word and then counts down to 0 over the data words.
- R7: Opcode 0x21 uses the same N and address fields. It reads N consecutive words into the reply queue, and `cmd_ready` stays low until all N have been queued. Each opcode 0x30 (read) returns the oldest queued word on `reply_word`, with `reply_valid` high in the same cycle as its progress word.
- R8: Opcode 0x10 queues the parameter VERSION. Opcode 0x11 queues {29'b0, err_flag, muted, playing}, sampled as the command is accepted.
- R9: The following words are rejected: an unknown opcode, a read with an empty queue, N = 0 for opcode 0x20 or 0x21, opcode 0x21 with N larger than the free queue space, and opcode 0x10 or 0x11 with a full queue. A rejected word sets bit 31 of its progress word (value 0x80000000) and sets the sticky `err_flag`. It changes nothing else.
- R10: The reply queue holds up to 16 words and returns them in the order they were queued.
- R11: After reset `playing`=0, `muted`=1, `flush`=0, `err_flag`=0, the queue is empty, no parameters are expected, and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host word valid |
| cmd_ready | output | 1 | Block can accept a word |
| cmd_word | input | 32 | Host command or parameter word |
| prog_valid | output | 1 | Progress word valid (one cycle) |
| prog_word | output | 32 | Error bit 31, remaining parameters [7:0] |
| reply_valid | output | 1 | Reply word valid (one cycle) |
| reply_word | output | 32 | Reply returned by a read command |
| playing | output | 1 | Operation running |
| muted | output | 1 | Audio output silenced |
| flush | output | 1 | One-cycle input-buffer flush strobe |
| err_flag | output | 1 | Sticky error flag |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after an enabled read |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Data words that look like commands.** Write data words are chosen to resemble read and unknown opcodes. A design that decoded data as commands would return error progress or pop replies.
- **Filling the reply queue exactly.** The queue is filled to exactly 16 entries, then a read of one more word and a version request are both attempted. A design with an off-by-one free-space check would either overflow and corrupt the order, or refuse a legal request.
- **Mute versus stop.** Mute and unmute are issued while playing, and the two stop opcodes are compared. A design that mixed these up would drop `playing` on mute or raise `flush` on a plain stop.
- **Reads and errors.** Reads are issued until the queue is empty and then once more. Several kinds of rejected command follow, and the bench checks that the error bit is set on each and that the error flag stays set.

// File: rtl/hci_pkg.sv
package hci_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_HI = 31;
  localparam int OPC_LO = 24;
  localparam int CNT_HI = 23;
  localparam int CNT_LO = 16;

  localparam logic [7:0] OPC_NOP    = 8'h00;
  localparam logic [7:0] OPC_PLAY   = 8'h01;
  localparam logic [7:0] OPC_MUTE   = 8'h02;
  localparam logic [7:0] OPC_UNMUTE = 8'h03;
  localparam logic [7:0] OPC_STOP   = 8'h04;
  localparam logic [7:0] OPC_STOPF  = 8'h05;
  localparam logic [7:0] OPC_VER    = 8'h10;
  localparam logic [7:0] OPC_STAT   = 8'h11;
  localparam logic [7:0] OPC_POKE   = 8'h20;
  localparam logic [7:0] OPC_PEEK   = 8'h21;
  localparam logic [7:0] OPC_READ   = 8'h30;

  typedef enum logic [3:0] {
    K_NOP, K_PLAY, K_MUTE, K_UNMUTE, K_STOP, K_STOPF,
    K_VER, K_STAT, K_POKE, K_PEEK, K_READ, K_BAD
  } cmd_kind_e;
endpackage

// File: rtl/hci_decode.sv
module hci_decode
  import hci_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_kind_e  kind
);
  always_comb begin
    case (opcode)
      OPC_NOP:    kind = K_NOP;
      OPC_PLAY:   kind = K_PLAY;
      OPC_MUTE:   kind = K_MUTE;
      OPC_UNMUTE: kind = K_UNMUTE;
      OPC_STOP:   kind = K_STOP;
      OPC_STOPF:  kind = K_STOPF;
      OPC_VER:    kind = K_VER;
      OPC_STAT:   kind = K_STAT;
      OPC_POKE:   kind = K_POKE;
      OPC_PEEK:   kind = K_PEEK;
      OPC_READ:   kind = K_READ;
      default:    kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/hci_play_ctl.sv
module hci_play_ctl (
  input  logic clk,
  input  logic rst,
  input  logic do_play,
  input  logic do_mute,
  input  logic do_unmute,
  input  logic do_stop,
  input  logic do_stopf,
  output logic playing,
  output logic muted,
  output logic flush
);
  always_ff @(posedge clk) begin
    if (rst) begin
      playing <= 1'b0;
      muted   <= 1'b1;
      flush   <= 1'b0;
    end else begin
      flush <= do_stopf;
      if (do_play) begin
        playing <= 1'b1;
        muted   <= 1'b0;
      end else if (do_stop || do_stopf) begin
        playing <= 1'b0;
        muted   <= 1'b1;
      end else if (do_mute) begin
        muted <= 1'b1;
      end else if (do_unmute) begin
        muted <= 1'b0;
      end
    end
  end

  // R1: start always leaves the output audible
  p_play_unmutes_r1: assert property (@(posedge clk) disable iff (rst)
    do_play |=> (playing && !muted));
  // R2: mute keeps the operation running
  p_mute_keeps_play_r2: assert property (@(posedge clk) disable iff (rst)
    do_mute |=> (muted && playing == $past(playing)));
  // R3: both stops halt and silence
  p_stop_mutes_r3: assert property (@(posedge clk) disable iff (rst)
    (do_stop || do_stopf) |=> (!playing && muted));
  // R3: a flush strobe only follows the flushing stop
  p_flush_from_stopf_r3: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(do_stopf));
endmodule

// File: rtl/hci_reply_fifo.sv
module hci_reply_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R10: the queue never takes a word when full
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));
  // R10: the queue never gives a word when empty
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/host_cmd_ctrl.sv
module host_cmd_ctrl
  import hci_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [31:0] VERSION    = 32'h0A0B_0C0D,
  localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_word,
  output logic              prog_valid,
  output logic [31:0]       prog_word,
  output logic              reply_valid,
  output logic [31:0]       reply_word,
  output logic              playing,
  output logic              muted,
  output logic              flush,
  output logic              err_flag,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata
);
  cmd_kind_e         kind;
  logic [7:0]        param_left;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        rd_left;
  logic              push_dly;
  logic              poke_mode, accept, is_cmd, bad, ok;
  logic [7:0]        n_field, next_left;
  logic [ADDR_W-1:0] addr_field;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [31:0]       fifo_din;
  logic [CNT_W-1:0]  fifo_count;
  logic [8:0]        free9;
  logic              reading;

  hci_decode u_dec (.opcode(cmd_word[OPC_HI:OPC_LO]), .kind(kind));

  assign poke_mode  = (param_left != 8'd0);
  assign reading    = ram_en && !ram_we;
  assign cmd_ready  = !reading && !push_dly;
  assign accept     = cmd_valid && cmd_ready;
  assign is_cmd     = accept && !poke_mode;
  assign n_field    = cmd_word[CNT_HI:CNT_LO];
  assign addr_field = cmd_word[ADDR_W-1:0];
  assign free9      = 9'(FIFO_DEPTH) - 9'(fifo_count);

  always_comb begin
    bad = 1'b0;
    if (is_cmd) begin
      case (kind)
        K_BAD:         bad = 1'b1;
        K_READ:        bad = fifo_empty;
        K_POKE:        bad = (n_field == 8'd0);
        K_PEEK:        bad = (n_field == 8'd0) || ({1'b0, n_field} > free9);
        K_VER, K_STAT: bad = fifo_full;
        default:       bad = 1'b0;
      endcase
    end
  end
  assign ok = is_cmd && !bad;

  always_comb begin
    if (poke_mode)                 next_left = param_left - 8'd1;
    else if (ok && kind == K_POKE) next_left = n_field;
    else                           next_left = 8'd0;
  end

  hci_play_ctl u_play (
    .clk(clk), .rst(rst),
    .do_play  (ok && kind == K_PLAY),
    .do_mute  (ok && kind == K_MUTE),
    .do_unmute(ok && kind == K_UNMUTE),
    .do_stop  (ok && kind == K_STOP),
    .do_stopf (ok && kind == K_STOPF),
    .playing(playing), .muted(muted), .flush(flush)
  );

  assign fifo_push = push_dly || (ok && (kind == K_VER || kind == K_STAT));
  assign fifo_pop  = ok && kind == K_READ;
  always_comb begin
    if (push_dly)          fifo_din = ram_rdata;
    else if (kind == K_VER) fifo_din = VERSION;
    else                    fifo_din = {29'b0, err_flag, muted, playing};
  end

  hci_reply_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(fifo_push), .din(fifo_din),
    .pop(fifo_pop), .dout(reply_word),
    .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_valid  <= 1'b0;
      prog_word   <= '0;
      reply_valid <= 1'b0;
      err_flag    <= 1'b0;
      param_left  <= 8'd0;
      wr_addr     <= '0;
      rd_left     <= 8'd0;
      push_dly    <= 1'b0;
      ram_en      <= 1'b0;
      ram_we      <= 1'b0;
      ram_addr    <= '0;
      ram_wdata   <= '0;
    end else begin
      prog_valid  <= accept;
      reply_valid <= fifo_pop;
      push_dly    <= reading;
      ram_en      <= 1'b0;
      ram_we      <= 1'b0;
      if (accept) prog_word <= {bad, 23'b0, next_left};
      if (bad) err_flag <= 1'b1;
      if (accept && poke_mode) begin
        ram_en     <= 1'b1;
        ram_we     <= 1'b1;
        ram_addr   <= wr_addr;
        ram_wdata  <= cmd_word;
        wr_addr    <= wr_addr + ADDR_W'(1);
        param_left <= param_left - 8'd1;
      end else if (ok && kind == K_POKE) begin
        param_left <= n_field;
        wr_addr    <= addr_field;
      end else if (ok && kind == K_PEEK) begin
        ram_en   <= 1'b1;
        ram_addr <= addr_field;
        rd_left  <= n_field - 8'd1;
      end else if (reading && rd_left != 8'd0) begin
        ram_en   <= 1'b1;
        ram_addr <= ram_addr + ADDR_W'(1);
        rd_left  <= rd_left - 8'd1;
      end
    end
  end

  // R5: each accepted word gets a progress word on the next cycle
  p_prog_follows_word_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> prog_valid);
  // R7: a reply only appears alongside a progress word
  p_reply_with_prog_r7: assert property (@(posedge clk) disable iff (rst)
    reply_valid |-> prog_valid);
  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R6: no RAM write happens unless a data word was taken
  p_write_needs_word_r6: assert property (@(posedge clk) disable iff (rst)
    (ram_en && ram_we) |-> $past(cmd_valid && cmd_ready));
endmodule

// File: tb/host_cmd_ctrl_bench.sv
module host_cmd_ctrl_bench;
  localparam logic [31:0] VER_C = 32'h0A0B_0C0D;
  localparam int          QD    = 16;
  localparam logic [31:0] ERRW  = 32'h8000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic cmd_ready, prog_valid, reply_valid, playing, muted, flush, err_flag;
  logic [31:0] prog_word, reply_word, ram_wdata, ram_rdata;
  logic ram_en, ram_we;
  logic [15:0] ram_addr;

  always #4 clk = ~clk;

  host_cmd_ctrl u_host_cmd_ctrl (.*);

  logic [31:0] ram [int];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= ram.exists(int'(ram_addr)) ? ram[int'(ram_addr)] : 32'h0;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] exp_prog[$], exp_reply[$], model_q[$];
  logic [31:0] exp_mem [int];
  logic m_play = 0, m_mute = 1, m_err = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (prog_valid) begin
        if (exp_prog.size() == 0) chk("R5 extra progress", 1, 0);
        else chk("R5 progress word", prog_word, exp_prog.pop_front());
      end
      if (reply_valid) begin
        if (exp_reply.size() == 0) chk("R7 extra reply", 1, 0);
        else chk("R7/R8/R10 reply word", reply_word, exp_reply.pop_front());
      end
    end
  end

  task automatic send(logic [31:0] w, logic [31:0] eprog);
    exp_prog.push_back(eprog);
    cmd_word  = w;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ctl(logic [7:0] op, string tag);
    send({op, 24'h0}, 32'h0);
    case (op)
      8'h01: begin m_play = 1; m_mute = 0; end
      8'h02: m_mute = 1;
      8'h03: m_mute = 0;
      8'h04, 8'h05: begin m_play = 0; m_mute = 1; end
      default: ;
    endcase
    chk({tag, " playing"}, playing, m_play);
    chk({tag, " muted"}, muted, m_mute);
    chk({tag, " flush"}, flush, op == 8'h05);
  endtask

  task automatic rd();
    if (model_q.size() == 0) begin
      m_err = 1;
      send(32'h3000_0000, ERRW);
    end else begin
      exp_reply.push_back(model_q.pop_front());
      send(32'h3000_0000, 32'h0);
    end
  endtask

  task automatic poke(logic [15:0] a, logic [7:0] n, logic [31:0] base);
    send({8'h20, n, a}, {24'h0, n});
    for (int i = 0; i < int'(n); i++) begin
      logic [31:0] d;
      d = (i == 0) ? 32'h3000_0000 : (i == 1) ? 32'h7F00_0000 : base ^ i;
      exp_mem[int'(a) + i] = d;
      send(d, 32'(int'(n) - 1 - i));
    end
  endtask

  task automatic peek(logic [15:0] a, logic [7:0] n);
    if (n == 0 || int'(n) > QD - model_q.size()) begin
      m_err = 1;
      send({8'h21, n, a}, ERRW);
    end else begin
      for (int i = 0; i < int'(n); i++) model_q.push_back(exp_mem[int'(a) + i]);
      send({8'h21, n, a}, 32'h0);
      chk("R7 busy during reads", cmd_ready, 1'b0);
    end
  endtask

  task automatic qreq(logic [7:0] op);
    if (model_q.size() == QD) begin
      m_err = 1;
      send({op, 24'h0}, ERRW);
    end else begin
      model_q.push_back(op == 8'h10 ? VER_C : {29'b0, m_err, m_mute, m_play});
      send({op, 24'h0}, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 playing", playing, 0);
    chk("R11 muted", muted, 1);
    chk("R11 flush", flush, 0);
    chk("R11 err_flag", err_flag, 0);
    chk("R11 cmd_ready", cmd_ready, 1);
    chk("R11 prog_valid", prog_valid, 0);
    ctl(8'h00, "R4 nop");
    ctl(8'h01, "R1 play");
    ctl(8'h02, "R2 mute");
    ctl(8'h00, "R4 nop while muted");
    ctl(8'h03, "R2 unmute");
    ctl(8'h04, "R3 stop");
    ctl(8'h01, "R1 play again");
    ctl(8'h05, "R3 stopf");
    @(negedge clk);
    chk("R3 flush one cycle", flush, 0);
    ctl(8'h01, "R1 play");
    qreq(8'h11);
    qreq(8'h10);
    rd(); rd();
    // R6 writes then R7 read back
    poke(16'h0100, 8'd4, 32'hA5A5_0000);
    peek(16'h0100, 8'd4);
    for (int i = 0; i < 4; i++) rd();
    poke(16'h2000, 8'd20, 32'h1234_0000);
    peek(16'h2000, 8'd10);
    peek(16'h200A, 8'd7);   // R9 exceeds free space
    chk("R9 err_flag set", err_flag, 1);
    peek(16'h200A, 8'd6);   // R10 fills to exactly 16
    qreq(8'h10);            // R9 full queue
    peek(16'h2000, 8'd1);   // R9 full queue
    for (int i = 0; i < QD; i++) rd();
    rd();                    // R9 empty read
    send(32'h7F00_0000, ERRW); // R9 unknown opcode
    send(32'h2000_0100, ERRW); // R9 zero count
    send(32'h2100_0100, ERRW); // R9 zero count
    chk("R9 state untouched playing", playing, m_play);
    chk("R9 state untouched muted", muted, m_mute);
    chk("R9 err_flag sticky", err_flag, 1);
    qreq(8'h11);
    rd();
    repeat (4) @(negedge clk);
    chk("R5 all progress seen", exp_prog.size(), 0);
    chk("R7 all replies seen", exp_reply.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule